// File: doc/BRIEF.md
# Periodic-Timer Queue Scan Controller

This block paces a queue of conversion command words from a free-running periodic timer. A programmable prescaler divides the system clock down to a conversion-clock enable. An interval timer counts those enables up to a power-of-two interval and emits a one-cycle trigger each time the interval elapses. A scan sequencer walks the command queue. It raises a convert request for the current command index and steps through the queue on each converter done pulse.

The same trigger does two jobs. When the sequencer has stopped at a command whose pause bit is set, the next trigger resumes the queue at the following command. When the sequencer has passed the end index, the next trigger restarts the queue at command zero. If a trigger arrives while a conversion is still pending, it sets an overrun flag and does nothing else. The pause, completion and overrun flags each stay set until a write-one clear strobe.

Top module: `qscan_ctrl`

## Requirements
- R1: The prescaler produces one conversion-clock tick every P+1 system clocks, where P is `presc_val`. After `scan_en` rises, the first `trig_o` pulse is visible after the N*(P+1)-th rising clock edge. Each later pulse follows N*(P+1) cycles after the previous one.
- R2: The interval is N = 2^(MIN_EXP + `ivl_sel`) conversion-clock ticks. Any select whose exponent would exceed MAX_EXP is held at 2^MAX_EXP.
- R3: `trig_o` pulses for one cycle each time the interval elapses, whether or not a conversion is pending.
- R4: A trigger while the queue is idle starts it at command 0. In the cycle after the `trig_o` pulse, `conv_req` is high and `cmd_idx` is 0.
- R5: When `conv_done` arrives for a command that is neither the end index nor paused, `cmd_idx` advances by one and `conv_req` stays high without a further trigger.
- R6: When `conv_done` arrives for a command whose bit in `pause_bits` is set and which is not the end index, `conv_req` drops, `pause_flag` sets and `cmd_idx` holds. The next trigger resumes at `cmd_idx`+1.
- R7: When `conv_done` arrives for the command equal to `end_idx`, `done_flag` sets, `cmd_idx` returns to 0 and `conv_req` drops. This takes precedence over that command's pause bit. The next trigger restarts the queue at command 0.
- R8: A trigger while `conv_req` is high sets `ovr_flag` and leaves `cmd_idx` and `conv_req` unchanged.
- R9: A one-cycle high on `clr_pause`, `clr_done` or `clr_ovr` clears the matching flag. A set event in the same cycle as its clear wins.
- R10: A change of `ivl_sel` resets the timer count. With P = 0, the next trigger is visible after the (N+1)-th edge, counting the edge that sees the change as the first, where N is the new interval.
- R11: While `scan_en` is low, the prescaler and timer counts are held at zero, `conv_req` is low and `cmd_idx` is 0. The flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Periodic scan mode enable |
| presc_val | input | PRESC_W | Prescale value P; tick every P+1 clocks |
| ivl_sel | input | SEL_W | Interval select; exponent MIN_EXP + value |
| pause_bits | input | NUM_CMDS | Pause marker per command word |
| end_idx | input | $clog2(NUM_CMDS) | Index of the last command in the queue |
| conv_done | input | 1 | Converter done pulse for the current command |
| clr_pause | input | 1 | Write-one clear of pause_flag |
| clr_done | input | 1 | Write-one clear of done_flag |
| clr_ovr | input | 1 | Write-one clear of ovr_flag |
| cmd_idx | output | $clog2(NUM_CMDS) | Current command index |
| conv_req | output | 1 | Convert request for cmd_idx |
| trig_o | output | 1 | One-cycle trigger pulse from the interval timer |
| pause_flag | output | 1 | Queue stopped at a pause marker |
| done_flag | output | 1 | Queue reached its end index |
| ovr_flag | output | 1 | Trigger arrived while a conversion was pending |

## Verification
The bench builds the block with MIN_EXP = 2, MAX_EXP = 5, SEL_W = 3, PRESC_W = 3 and NUM_CMDS = 8. These values make the intervals 4 to 32 ticks long, so every prescale value from 0 to 3 can be swept against every select value. Selects 4 to 7 land past MAX_EXP and exercise the clamp. The intervals are short enough that pause, resume, end-of-queue restart and overrun all happen within a few hundred cycles, each at a known trigger position.

// File: rtl/qscan_pkg.sv
package qscan_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_CONV  = 2'd1,
        SQ_PAUSE = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic pause;
        logic done;
        logic ovr;
    } sq_flags_t;

    // exponent of the selected interval, held at the upper limit
    function automatic int unsigned ivl_exp(input int unsigned min_e,
                                            input int unsigned max_e,
                                            input int unsigned sel);
        int unsigned e;
        e = min_e + sel;
        if (e > max_e) e = max_e;
        return e;
    endfunction

endpackage

// File: rtl/qscan_presc.sv
module qscan_presc #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PRESC_W-1:0] div,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt;

    assign tick = en && (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || !en)  cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (!tick || div == '0));

endmodule

// File: rtl/qscan_timer.sv
module qscan_timer
    import qscan_pkg::*;
#(
    parameter int MIN_EXP = 7,
    parameter int MAX_EXP = 17,
    parameter int SEL_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             trig
);
    localparam int CNT_W = MAX_EXP;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;
    logic [SEL_W-1:0] sel_q;
    int unsigned      exp_now;

    always_comb begin
        exp_now = ivl_exp(MIN_EXP, MAX_EXP, int'(sel));
        term    = {CNT_W{1'b1}} >> (MAX_EXP - exp_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sel_q <= '0;
            trig  <= 1'b0;
        end else begin
            sel_q <= sel;
            trig  <= 1'b0;
            if (!en || sel != sel_q) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt >= term) begin
                    cnt  <= '0;
                    trig <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    initial begin
        min_exp_ok_chk: assert (MIN_EXP >= 1 && MAX_EXP >= MIN_EXP);
    end

    // R2
    trig_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(tick));

    // R3
    trig_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

endmodule

// File: rtl/qscan_seq.sv
module qscan_seq
    import qscan_pkg::*;
#(
    parameter int NCMD  = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             trig,
    input  logic [NCMD-1:0]  pause_bits,
    input  logic [IDX_W-1:0] end_idx,
    input  logic             conv_done,
    input  logic             clr_pause,
    input  logic             clr_done,
    input  logic             clr_ovr,
    output logic [IDX_W-1:0] idx,
    output logic             conv_req,
    output sq_flags_t        flags
);
    sq_state_e state;
    sq_flags_t set_f;
    logic      at_end;
    logic      busy_done;

    assign conv_req  = (state == SQ_CONV);
    assign at_end    = (idx == end_idx);
    assign busy_done = en && conv_req && conv_done;

    always_comb begin
        set_f.done  = busy_done && at_end;
        set_f.pause = busy_done && !at_end && pause_bits[idx];
        set_f.ovr   = en && conv_req && trig;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            idx   <= '0;
            flags <= '0;
        end else begin
            flags.pause <= set_f.pause | (flags.pause & ~clr_pause);
            flags.done  <= set_f.done  | (flags.done  & ~clr_done);
            flags.ovr   <= set_f.ovr   | (flags.ovr   & ~clr_ovr);
            if (!en) begin
                state <= SQ_IDLE;
                idx   <= '0;
            end else begin
                case (state)
                    SQ_IDLE: if (trig) begin
                        state <= SQ_CONV;
                        idx   <= '0;
                    end
                    SQ_PAUSE: if (trig) begin
                        state <= SQ_CONV;
                        idx   <= idx + 1'b1;
                    end
                    SQ_CONV: if (conv_done) begin
                        if (at_end) begin
                            state <= SQ_IDLE;
                            idx   <= '0;
                        end else if (pause_bits[idx]) begin
                            state <= SQ_PAUSE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && en && trig) |=> (conv_req && idx == '0));

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done && en) |=> $stable(idx));

    // R7
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.done) |-> ($past(idx) == $past(end_idx) && idx == '0));

    // R8
    ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ovr) |-> $past(conv_req && trig));

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!conv_req && idx == '0));

endmodule

// File: rtl/qscan_ctrl.sv
module qscan_ctrl
    import qscan_pkg::*;
#(
    parameter int PRESC_W  = 8,
    parameter int NUM_CMDS = 16,
    parameter int SEL_W    = 4,
    parameter int MIN_EXP  = 7,
    parameter int MAX_EXP  = 17,
    localparam int IDX_W   = $clog2(NUM_CMDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scan_en,
    input  logic [PRESC_W-1:0]  presc_val,
    input  logic [SEL_W-1:0]    ivl_sel,
    input  logic [NUM_CMDS-1:0] pause_bits,
    input  logic [IDX_W-1:0]    end_idx,
    input  logic                conv_done,
    input  logic                clr_pause,
    input  logic                clr_done,
    input  logic                clr_ovr,
    output logic [IDX_W-1:0]    cmd_idx,
    output logic                conv_req,
    output logic                trig_o,
    output logic                pause_flag,
    output logic                done_flag,
    output logic                ovr_flag
);
    logic      qtick;
    sq_flags_t flags;

    qscan_presc #(.PRESC_W(PRESC_W)) presc_i (
        .clk  (clk),
        .rst  (rst),
        .en   (scan_en),
        .div  (presc_val),
        .tick (qtick)
    );

    qscan_timer #(.MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP), .SEL_W(SEL_W)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .en   (scan_en),
        .tick (qtick),
        .sel  (ivl_sel),
        .trig (trig_o)
    );

    qscan_seq #(.NCMD(NUM_CMDS), .IDX_W(IDX_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .en         (scan_en),
        .trig       (trig_o),
        .pause_bits (pause_bits),
        .end_idx    (end_idx),
        .conv_done  (conv_done),
        .clr_pause  (clr_pause),
        .clr_done   (clr_done),
        .clr_ovr    (clr_ovr),
        .idx        (cmd_idx),
        .conv_req   (conv_req),
        .flags      (flags)
    );

    assign pause_flag = flags.pause;
    assign done_flag  = flags.done;
    assign ovr_flag   = flags.ovr;

endmodule

// File: tb/qscan_ctrl_tb_top.sv
module qscan_ctrl_tb_top;
    localparam int PW = 3, NC = 8, SW = 3, MINE = 2, MAXE = 5;
    localparam int IW = $clog2(NC);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_en = 1'b0;
    logic [PW-1:0] presc_val = '0;
    logic [SW-1:0] ivl_sel = '0;
    logic [NC-1:0] pause_bits = '0;
    logic [IW-1:0] end_idx = '0;
    logic          conv_done = 1'b0;
    logic          clr_pause = 1'b0, clr_done = 1'b0, clr_ovr = 1'b0;
    logic [IW-1:0] cmd_idx;
    logic          conv_req, trig_o, pause_flag, done_flag, ovr_flag;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    qscan_ctrl #(.PRESC_W(PW), .NUM_CMDS(NC), .SEL_W(SW),
                 .MIN_EXP(MINE), .MAX_EXP(MAXE)) dut_i (
        .clk(clk), .rst(rst), .scan_en(scan_en), .presc_val(presc_val),
        .ivl_sel(ivl_sel), .pause_bits(pause_bits), .end_idx(end_idx),
        .conv_done(conv_done), .clr_pause(clr_pause), .clr_done(clr_done),
        .clr_ovr(clr_ovr), .cmd_idx(cmd_idx), .conv_req(conv_req),
        .trig_o(trig_o), .pause_flag(pause_flag), .done_flag(done_flag),
        .ovr_flag(ovr_flag)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    task automatic cnt_trig(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!trig_o && n < 5000);
    endtask

    function automatic int ivl(input int s);
        int e;
        e = MINE + s;
        if (e > MAXE) e = MAXE;
        return 1 << e;
    endfunction

    task automatic do_conv(input int exp_idx, input string req, input bit with_clr);
        chk(conv_req && cmd_idx == IW'(exp_idx), req, int'(cmd_idx), exp_idx);
        conv_done = 1'b1;
        clr_done  = with_clr;
        @(negedge clk);
        conv_done = 1'b0;
        clr_done  = 1'b0;
    endtask

    task automatic strobe(input int which);
        clr_pause = (which == 0);
        clr_done  = (which == 1);
        clr_ovr   = (which == 2);
        @(negedge clk);
        clr_pause = 1'b0; clr_done = 1'b0; clr_ovr = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, R11 idle outputs
        chk(!conv_req && !trig_o && cmd_idx == 0 && !pause_flag && !done_flag && !ovr_flag,
            "R11 reset", int'(conv_req), 0);

        // R1 R2: sweep prescale and select
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 8; s++) begin
                scan_en = 1'b0; presc_val = PW'(p); ivl_sel = SW'(s);
                @(negedge clk);
                scan_en = 1'b1;
                cnt_trig(n);
                chk(n == ivl(s) * (p + 1), "R1 R2 first", n, ivl(s) * (p + 1));
                cnt_trig(n);
                chk(n == ivl(s) * (p + 1), "R1 R2 period", n, ivl(s) * (p + 1));
            end
        end

        // queue sequencing, P=0, N=32
        scan_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        presc_val = '0; ivl_sel = 3'd3; end_idx = 3'd3; pause_bits = 8'b0000_1010;
        @(negedge clk);
        scan_en = 1'b1;
        cnt_trig(n);
        chk(n == 32, "R1 queue first", n, 32);
        @(negedge clk);
        chk(conv_req && cmd_idx == 0, "R4 start", int'(cmd_idx), 0);
        do_conv(0, "R4 cmd0", 1'b0);
        chk(conv_req && cmd_idx == 1, "R5 advance", int'(cmd_idx), 1);
        do_conv(1, "R5 cmd1", 1'b0);
        chk(!conv_req && pause_flag && cmd_idx == 1, "R6 pause", int'(cmd_idx), 1);
        cnt_trig(n);
        @(negedge clk);
        chk(conv_req && cmd_idx == 2, "R6 resume", int'(cmd_idx), 2);
        do_conv(2, "R5 cmd2", 1'b0);
        strobe(0);
        chk(!pause_flag, "R9 clr pause", int'(pause_flag), 0);
        do_conv(3, "R7 cmd3", 1'b1);
        chk(done_flag, "R9 set wins", int'(done_flag), 1);
        chk(!conv_req && !pause_flag && cmd_idx == 0, "R7 end over pause",
            int'(pause_flag), 0);
        strobe(1);
        chk(!done_flag, "R9 clr done", int'(done_flag), 0);
        cnt_trig(n);
        @(negedge clk);
        chk(conv_req && cmd_idx == 0, "R7 restart", int'(cmd_idx), 0);
        cnt_trig(n);
        chk(n == 31, "R3 trig while busy", n, 31);
        @(negedge clk);
        chk(ovr_flag && conv_req && cmd_idx == 0, "R8 overrun", int'(ovr_flag), 1);

        // R11 disable
        scan_en = 1'b0;
        @(negedge clk);
        chk(!conv_req && cmd_idx == 0 && ovr_flag, "R11 disable", int'(conv_req), 0);
        scan_en = 1'b1;
        cnt_trig(n);
        chk(n == 32, "R11 timer cleared", n, 32);
        strobe(2);
        chk(!ovr_flag, "R9 clr ovr", int'(ovr_flag), 0);

        // R10 select change
        repeat (10) @(negedge clk);
        ivl_sel = 3'd0;
        cnt_trig(n);
        chk(n == 5, "R10 sel to 4", n, 5);
        repeat (2) @(negedge clk);
        ivl_sel = 3'd3;
        cnt_trig(n);
        chk(n == 33, "R10 sel to 32", n, 33);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule